// File: doc/BRIEF.md
# Codec Channel Loopback Path Selector

This block steers the sample streams of one voice codec channel between four attachment points: the PCM bus port, the receive and transmit sides of the digital filter chain, and the digital streams of the delta-sigma converters. In normal operation it simply forwards each stream to the next stage. For line-card testing it can instead turn traffic around at one of five points. These points cover the PCM port itself, the converter edge of the filter chain, a loop that includes the conversions, the digital side of the converters, and the PCM edge seen from the line side.

A 3-bit test-mode request is sampled only on a frame-sync pulse, so a change of loop point always starts on a frame boundary. A standby input forces both outbound streams to a fixed idle code whatever loop is active. All routing is combinational from the inputs and the latched mode.

Top module: `codec_loop_sel`

## Requirements
- R1: After reset the latched mode is normal (code 0), so all four streams are forwarded straight through and `conv_loop_o` is low.
- R2: In normal mode (code 0) the routing is `dsp_rx_o = pcm_rx_i`, `cnv_rx_o = dsp_rx_i`, `dsp_tx_o = cnv_tx_i`, `pcm_tx_o = dsp_tx_i`, and `conv_loop_o = 0`.
- R3: In code 1 (PCM port loop), `pcm_tx_o` carries `pcm_rx_i`. The other three stream outputs keep their normal routing.
- R4: In code 2 (filter-chain loop at the converter edge), `dsp_tx_o` carries `dsp_rx_i`. The other stream outputs keep their normal routing.
- R5: In code 3 (loop including the conversions), all streams keep their normal routing and `conv_loop_o` is high, which asks the converters to close their loop.
- R6: In code 4 (loop at the digital side of the converters), `cnv_rx_o` carries `cnv_tx_i`. The other stream outputs keep their normal routing.
- R7: In code 5 (line-side loop at the PCM edge), `dsp_rx_o` carries `dsp_tx_i`. The other stream outputs keep their normal routing.
- R8: A requested code of 6 or 7 is latched as normal mode (code 0).
- R9: `mode_req` is latched only on a clock edge with `fsync` high. At any other edge the active routing does not change.
- R10: While `standby` is high, `pcm_tx_o` and `cnv_rx_o` equal the idle code (parameter `IDLE`, default 8'hD5) and `conv_loop_o` is low, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame-sync pulse; mode request latched when high |
| standby | input | 1 | Channel standby; idles outbound streams |
| mode_req | input | 3 | Requested loopback code |
| pcm_rx_i | input | W | Sample received from the PCM bus |
| pcm_tx_o | output | W | Sample sent to the PCM bus |
| dsp_rx_o | output | W | Sample into the receive filter chain |
| dsp_rx_i | input | W | Sample out of the receive filter chain |
| dsp_tx_o | output | W | Sample into the transmit filter chain |
| dsp_tx_i | input | W | Sample out of the transmit filter chain |
| cnv_rx_o | output | W | Stream to the receive converter |
| cnv_tx_i | input | W | Stream from the transmit converter |
| conv_loop_o | output | 1 | Request to close the loop through the conversions |

## Verification
The latched mode is the only state in the block. If it is wrong, the wrong source appears on a stream output in the same cycle as the next sample, or `conv_loop_o` changes wrongly. A mode latched off a frame boundary shows on the first edge without `fsync` after the request changes. An illegal code that is kept shows as an unexpected loop on the first sample after the frame pulse. Every check therefore drives distinct values on all four stream inputs, so that any misrouted output can be told apart from the correct one.

// File: rtl/codec_loop_sel.sv
module codec_loop_sel #(
  parameter int W = 8,
  parameter logic [W-1:0] IDLE = 8'hD5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fsync,
  input  logic         standby,
  input  logic [2:0]   mode_req,
  input  logic [W-1:0] pcm_rx_i,
  output logic [W-1:0] pcm_tx_o,
  output logic [W-1:0] dsp_rx_o,
  input  logic [W-1:0] dsp_rx_i,
  output logic [W-1:0] dsp_tx_o,
  input  logic [W-1:0] dsp_tx_i,
  output logic [W-1:0] cnv_rx_o,
  input  logic [W-1:0] cnv_tx_i,
  output logic         conv_loop_o
);
  localparam logic [2:0] M_NORM = 3'd0;
  localparam logic [2:0] M_PCM  = 3'd1;
  localparam logic [2:0] M_DIG  = 3'd2;
  localparam logic [2:0] M_CONV = 3'd3;
  localparam logic [2:0] M_ADS  = 3'd4;
  localparam logic [2:0] M_LINE = 3'd5;

  logic [2:0] mode_q;
  wire  [2:0] mode_ok = (mode_req > M_LINE) ? M_NORM : mode_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     mode_q <= M_NORM;
    else if (fsync) mode_q <= mode_ok;

  assign dsp_rx_o    = (mode_q == M_LINE) ? dsp_tx_i : pcm_rx_i;
  assign dsp_tx_o    = (mode_q == M_DIG)  ? dsp_rx_i : cnv_tx_i;
  assign pcm_tx_o    = standby ? IDLE : (mode_q == M_PCM) ? pcm_rx_i : dsp_tx_i;
  assign cnv_rx_o    = standby ? IDLE : (mode_q == M_ADS) ? cnv_tx_i : dsp_rx_i;
  assign conv_loop_o = !standby && (mode_q == M_CONV);

  assert_frame_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fsync |=> $stable(mode_q));
  assert_legal_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q <= M_LINE);
  assert_standby_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (pcm_tx_o == IDLE && cnv_rx_o == IDLE && !conv_loop_o));
  assert_pcm_loop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && mode_q == M_PCM) |-> pcm_tx_o == pcm_rx_i);
  assert_ads_loop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && mode_q == M_ADS) |-> cnv_rx_o == cnv_tx_i);
  assert_one_loop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_loop_o |-> (dsp_tx_o == cnv_tx_i && dsp_rx_o == pcm_rx_i));
endmodule

// File: tb/sim_codec_loop_sel.sv
module sim_codec_loop_sel;
  localparam int W = 8;
  localparam logic [W-1:0] IDLE = 8'hD5;

  logic clk = 0, rst_n = 0, fsync = 0, standby = 0;
  logic [2:0] mode_req = 0;
  logic [W-1:0] pcm_rx_i = 0, dsp_rx_i = 0, dsp_tx_i = 0, cnv_tx_i = 0;
  logic [W-1:0] pcm_tx_o, dsp_rx_o, dsp_tx_o, cnv_rx_o;
  logic conv_loop_o;

  always #2 clk = ~clk;

  codec_loop_sel #(.W(W), .IDLE(IDLE)) u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .standby(standby), .mode_req(mode_req),
    .pcm_rx_i(pcm_rx_i), .pcm_tx_o(pcm_tx_o), .dsp_rx_o(dsp_rx_o), .dsp_rx_i(dsp_rx_i),
    .dsp_tx_o(dsp_tx_o), .dsp_tx_i(dsp_tx_i), .cnv_rx_o(cnv_rx_o), .cnv_tx_i(cnv_tx_i),
    .conv_loop_o(conv_loop_o));

  typedef struct {
    logic [W-1:0] ptx, drx, dtx, crx;
    logic         lp;
    string        tag;
  } exp_t;

  exp_t sb[$];
  event go;
  int checks = 0, errors = 0;
  int eff_mode = 0;
  int n = 0;
  bit done = 0;

  task automatic push_check(input string tag);
    exp_t e;
    @(negedge clk);
    n++;
    pcm_rx_i = 8'h10 + n[7:0]; dsp_rx_i = 8'h40 + n[7:0];
    dsp_tx_i = 8'h70 + n[7:0]; cnv_tx_i = 8'hA0 + n[7:0];
    e.tag = tag;
    e.drx = (eff_mode == 5) ? dsp_tx_i : pcm_rx_i;
    e.dtx = (eff_mode == 2) ? dsp_rx_i : cnv_tx_i;
    e.ptx = standby ? IDLE : (eff_mode == 1) ? pcm_rx_i : dsp_tx_i;
    e.crx = standby ? IDLE : (eff_mode == 4) ? cnv_tx_i : dsp_rx_i;
    e.lp  = !standby && eff_mode == 3;
    sb.push_back(e);
    -> go;
    #1;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode_req = m; fsync = 1;
    @(negedge clk);
    fsync = 0;
    eff_mode = (m > 5) ? 0 : int'(m);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(go);
      #0.5;
      e = sb.pop_front();
      checks++;
      if (pcm_tx_o !== e.ptx || dsp_rx_o !== e.drx || dsp_tx_o !== e.dtx ||
          cnv_rx_o !== e.crx || conv_loop_o !== e.lp) begin
        errors++;
        $display("FAIL %s: got ptx=%h drx=%h dtx=%h crx=%h lp=%b exp ptx=%h drx=%h dtx=%h crx=%h lp=%b",
                 e.tag, pcm_tx_o, dsp_rx_o, dsp_tx_o, cnv_rx_o, conv_loop_o,
                 e.ptx, e.drx, e.dtx, e.crx, e.lp);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    push_check("R1 reset state");
    push_check("R2 normal a");
    push_check("R2 normal b");
    set_mode(3'd1); push_check("R3 pcm loop"); push_check("R3 pcm loop b");
    set_mode(3'd2); push_check("R4 digital loop");
    set_mode(3'd3); push_check("R5 conversion loop");
    set_mode(3'd4); push_check("R6 converter digital loop");
    set_mode(3'd5); push_check("R7 line pcm loop");
    set_mode(3'd6); push_check("R8 code 6 normal");
    set_mode(3'd5);
    set_mode(3'd7); push_check("R8 code 7 normal");
    @(negedge clk); mode_req = 3'd1;
    repeat (3) @(posedge clk);
    push_check("R9 hold without fsync");
    @(negedge clk); fsync = 1;
    @(negedge clk); fsync = 0; mode_req = 3'd4; eff_mode = 1;
    push_check("R9 latched at fsync");
    standby = 1;
    push_check("R10 standby pcm loop");
    set_mode(3'd4); push_check("R10 standby ads loop");
    set_mode(3'd3); push_check("R10 standby conv loop");
    standby = 0;
    push_check("R5 after standby");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule